// File: doc/BRIEF.md
# Buffered 8/16-bit Tick Counter

This peripheral counts events for a processor. The events are either internal instruction-cycle ticks, offered as a one-clock pulse on `tick`, or edges of an asynchronous pin that is first synchronized to the block clock. Events can pass through a power-of-two prescaler or go straight to the counter. The counter is 8 or 16 bits wide. When it wraps to zero it sets a sticky overflow flag, and the flag drives an interrupt line through an enable bit.

Software reaches the block through a byte register bus. The bus has an address, write data, a write strobe, a read strobe and combinational read data. There is no back-pressure: every access completes in the clock cycle in which its strobe is high, so the bus needs no valid/ready pair. The upper byte of the count is reached only through a holding register. Reading the low byte copies the live upper byte into the holding register. Writing the low byte moves the holding register into the upper byte in the same edge. Software therefore always moves the 16-bit value as one unit. Reads are side-effect free except for the low-byte read strobe.

Register addresses: 0 is the count low byte, 1 is the upper-byte holding register, 2 is control, and 3 is status. Control bits are: 7 run, 6 narrow (8-bit) mode, 5 pin source, 4 falling edge, 3 prescaler bypass, 2:0 prescale exponent. Status bits are: 0 overflow flag, 1 interrupt enable, 7:2 read as zero.

Top module: `tick_counter`

## Requirements
- R1: After reset, control reads FFh, and the count low byte, holding register and status all read 00h. `irq` is low.
- R2: With run set (bit 7), pin source clear (bit 5) and bypass set (bit 3), the count rises by one for each clock in which `tick` is high.
- R3: With pin source set, the count rises on rising pin edges when bit 4 is clear and on falling edges when bit 4 is set. A pin change first sampled at clock edge k advances the count at edge k+2.
- R4: With bypass clear, the count rises once per 2^(bits 2:0 + 1) source events, from 1:2 up to 1:256.
- R5: A write to address 0 clears the prescaler count. Control keeps the value it had before that write.
- R6: After a write to address 0, the next two `tick` pulses let no event through to the prescaler or counter, whatever the source. Events in the write cycle are also dropped.
- R7: A read strobe at address 0 copies the live upper byte into the holding register (address 1) at that edge. If an increment happens in the same cycle, the copied value is the upper byte from before that increment.
- R8: A write to address 0 loads the low byte from the write data and the upper byte from the holding register, both at the same edge.
- R9: The overflow flag is set when the count wraps from FFFFh to 0000h in 16-bit mode (bit 6 clear), or when the low byte wraps from FFh to 00h in 8-bit mode. In 8-bit mode the upper byte keeps its value.
- R10: The flag stays set until a status write with bit 0 clear. If that write falls in the same cycle as an overflow, the flag ends set.
- R11: `irq` is high exactly when the status flag and status bit 1 (enable) are both set.
- R12: With run clear, the count does not change except by a write to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Instruction-cycle tick, one clock per pulse |
| ext_pin | input | 1 | Asynchronous external event pin |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (side effect at address 0 only) |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Overflow interrupt |

## Verification
Two functions can fall in the same cycle, and the bench provokes both. In the first, a status write that clears the flag lands in the cycle in which the low byte wraps. The bench holds the count at FFh with no hold pending, raises `tick` and writes 00h to status in that one cycle, then expects the flag to read back set. In the second, a low-byte read strobe coincides with an increment that carries into the upper byte. The bench expects the holding register to show the upper byte from before the carry and the count to show the carried value. A behavioural reference model is stepped on every clock and compared with the read data and `irq`.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int BYTE_W     = 8;
  localparam int RATIO_BITS = 3;

  localparam int ADDR_LO   = 0;
  localparam int ADDR_HBUF = 1;
  localparam int ADDR_CTRL = 2;
  localparam int ADDR_STAT = 3;

  typedef struct packed {
    logic                  run;
    logic                  narrow;
    logic                  pin_src;
    logic                  fall_edge;
    logic                  bypass;
    logic [RATIO_BITS-1:0] ratio;
  } ctrl_t;
endpackage

// File: rtl/tc_edge_sync.sv
module tc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_sel,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q[0] <= pin;
      for (int i = 1; i < STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[STAGES-1];
    end
  end

  logic rise, fall;
  assign rise   = sync_q[STAGES-1] & ~prev_q;
  assign fall   = ~sync_q[STAGES-1] & prev_q;
  assign edge_o = fall_sel ? fall : rise;

  // R3: a reported edge means the synchronized level changed at the last edge
  p_edge_is_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |-> (sync_q[STAGES-1] != prev_q));
endmodule

// File: rtl/tc_prescaler.sv
module tc_prescaler #(
  parameter int PRE_W   = 8,
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               evt_in,
  input  logic               bypass,
  input  logic [RATIO_W-1:0] ratio,
  output logic               evt_out
);
  logic [PRE_W-1:0] pre_q;
  logic [RATIO_W:0] shamt;
  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] mask;
  logic             terminal;

  always_comb begin
    shamt    = {1'b0, ratio} + (RATIO_W+1)'(1);
    span     = (PRE_W+1)'(1) << shamt;
    mask     = PRE_W'(span - (PRE_W+1)'(1));
    terminal = ((pre_q | ~mask) == '1);
  end

  assign evt_out = bypass ? evt_in : (evt_in && terminal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pre_q <= '0;
    else if (clr)                pre_q <= '0;
    else if (evt_in && !bypass)  pre_q <= pre_q + PRE_W'(1);
  end

  p_pre_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pre_q == '0));
  // R4: bypassed path leaves the divider frozen
  p_pre_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && !clr) |=> $stable(pre_q));
endmodule

// File: rtl/tc_count_core.sv
module tc_count_core #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          narrow,
  input  logic          load,
  input  logic [BW-1:0] load_lo,
  input  logic [BW-1:0] load_hi,
  output logic [BW-1:0] lo_o,
  output logic [BW-1:0] hi_o,
  output logic          wrap_o
);
  logic [BW-1:0] lo_q, hi_q;

  assign wrap_o = inc && !load && (narrow ? (&lo_q) : (&{hi_q, lo_q}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (load) begin
      lo_q <= load_lo;
      hi_q <= load_hi;
    end else if (inc) begin
      if (narrow) lo_q <= lo_q + BW'(1);
      else        {hi_q, lo_q} <= {hi_q, lo_q} + (2*BW)'(1);
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  p_hi_hold_narrow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow && !load) |=> $stable(hi_q));
  p_wrap_to_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (lo_q == '0));
endmodule

// File: rtl/tick_counter.sv
module tick_counter
  import tc_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_W       = 8,
  parameter int HOLD_TICKS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ext_pin,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [7:0]        bus_rdata,
  output logic              irq
);
  localparam int HOLD_W = $clog2(HOLD_TICKS + 1);

  ctrl_t             ctrl_q;
  logic [BYTE_W-1:0] hbuf_q;
  logic              flag_q, ie_q;
  logic [HOLD_W-1:0] hold_q;

  logic wr_lo, wr_hbuf, wr_ctrl, wr_stat, rd_lo;
  assign wr_lo   = bus_we && (bus_addr == ADDR_W'(ADDR_LO));
  assign wr_hbuf = bus_we && (bus_addr == ADDR_W'(ADDR_HBUF));
  assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(ADDR_CTRL));
  assign wr_stat = bus_we && (bus_addr == ADDR_W'(ADDR_STAT));
  assign rd_lo   = bus_re && (bus_addr == ADDR_W'(ADDR_LO));

  logic pin_edge, raw_evt, pre_in, cnt_inc, wrap;
  logic [BYTE_W-1:0] cnt_lo, cnt_hi;

  tc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin),
    .fall_sel(ctrl_q.fall_edge), .edge_o(pin_edge));

  assign raw_evt = ctrl_q.pin_src ? pin_edge : tick;
  assign pre_in  = ctrl_q.run && (hold_q == '0) && !wr_lo && raw_evt;

  tc_prescaler #(.PRE_W(PRE_W), .RATIO_W(RATIO_BITS)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(wr_lo), .evt_in(pre_in),
    .bypass(ctrl_q.bypass), .ratio(ctrl_q.ratio), .evt_out(cnt_inc));

  tc_count_core #(.BW(BYTE_W)) u_core (
    .clk(clk), .rst_n(rst_n), .inc(cnt_inc), .narrow(ctrl_q.narrow),
    .load(wr_lo), .load_lo(bus_wdata), .load_hi(hbuf_q),
    .lo_o(cnt_lo), .hi_o(cnt_hi), .wrap_o(wrap));

  // post-write hold: counts down on ticks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       hold_q <= '0;
    else if (wr_lo)                   hold_q <= HOLD_W'(HOLD_TICKS);
    else if (tick && hold_q != '0)    hold_q <= hold_q - HOLD_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '1;
      hbuf_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata);
      if (wr_hbuf)    hbuf_q <= bus_wdata;
      else if (rd_lo) hbuf_q <= cnt_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      if (wr_stat) begin
        flag_q <= bus_wdata[0];
        ie_q   <= bus_wdata[1];
      end
      if (wrap) flag_q <= 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_W'(ADDR_LO):   bus_rdata = cnt_lo;
      ADDR_W'(ADDR_HBUF): bus_rdata = hbuf_q;
      ADDR_W'(ADDR_CTRL): bus_rdata = ctrl_q;
      ADDR_W'(ADDR_STAT): bus_rdata = {6'b0, ie_q, flag_q};
      default:            bus_rdata = '0;
    endcase
  end

  assign irq = flag_q & ie_q;

  p_hold_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q != '0 && !wr_lo) |=> $stable({cnt_hi, cnt_lo}));
  p_off_freeze_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !wr_lo) |=> $stable({cnt_hi, cnt_lo}));
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !wr_stat) |=> flag_q);
  p_wrap_sets_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag_q);
  p_load_atomic_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (cnt_hi == $past(hbuf_q) && cnt_lo == $past(bus_wdata)));
  p_read_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !wr_hbuf) |=> (hbuf_q == $past(cnt_hi)));
endmodule

// File: tb/tick_counter_tb.sv
`timescale 1ns/1ps
module tick_counter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       ext_pin = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [7:0] bus_rdata;
  logic       irq;

  always #2 clk = ~clk;

  tick_counter u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ext_pin(ext_pin),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_re(bus_re), .bus_rdata(bus_rdata), .irq(irq));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // ---------------- reference model ----------------
  logic [7:0] m_lo, m_hi, m_buf, m_ctrl;
  logic       m_flag, m_ie, s1, s2, sp;
  int         m_pre, m_hold;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_buf = 0; m_ctrl = 8'hFF;
      m_flag = 0; m_ie = 0; m_pre = 0; m_hold = 0;
      s1 = 0; s2 = 0; sp = 0;
    end else begin
      logic ev, fire, wrap, wlo;
      logic [7:0] old_hi;
      int ratio, full;
      old_hi = m_hi;
      ev = m_ctrl[5] ? (m_ctrl[4] ? (!s2 && sp) : (s2 && !sp)) : tick;
      wlo = bus_we && bus_addr == 0;
      fire = 0; wrap = 0;
      if (m_ctrl[7] && m_hold == 0 && !wlo && ev) begin
        if (m_ctrl[3]) fire = 1;
        else begin
          ratio = 1 << (m_ctrl[2:0] + 1);
          if (((m_pre + 1) % ratio) == 0) fire = 1;
          m_pre = (m_pre + 1) % 256;
        end
      end
      if (wlo) begin
        m_lo = bus_wdata; m_hi = m_buf; m_pre = 0; m_hold = 2;
      end else begin
        if (tick && m_hold > 0) m_hold = m_hold - 1;
        if (fire) begin
          if (m_ctrl[6]) begin
            wrap = (m_lo == 8'hFF); m_lo = m_lo + 8'd1;
          end else begin
            full = {m_hi, m_lo};
            wrap = (full == 65535);
            full = (full + 1) % 65536;
            m_lo = full[7:0]; m_hi = full[15:8];
          end
        end
      end
      if (bus_we && bus_addr == 1) m_buf = bus_wdata;
      else if (bus_re && bus_addr == 0) m_buf = old_hi;
      if (bus_we && bus_addr == 2) m_ctrl = bus_wdata;
      if (bus_we && bus_addr == 3) begin m_flag = bus_wdata[0]; m_ie = bus_wdata[1]; end
      if (wrap) m_flag = 1;
      sp = s2; s2 = s1; s1 = ext_pin;
    end
  end

  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_lo;
      2'd1: return m_buf;
      2'd2: return m_ctrl;
      default: return {6'b0, m_ie, m_flag};
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(bus_addr == 0 ? "R2 model low byte" : bus_addr == 1 ? "R7 model holding" :
            bus_addr == 2 ? "R5 model control" : "R10 model status",
            bus_rdata, m_read(bus_addr));
      check("R11 model irq", irq, m_flag & m_ie);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(); @(negedge clk); #1; endtask
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1; cyc(); bus_we = 0;
  endtask
  task automatic rd(input logic [1:0] a);
    bus_addr = a; bus_re = 1; cyc(); bus_re = 0;
  endtask
  task automatic ticks(input int n);
    tick = 1; repeat (n) cyc(); tick = 0;
  endtask
  task automatic peek(input logic [1:0] a, input int exp, input string tag);
    bus_addr = a; cyc(); check(tag, bus_rdata, exp);
  endtask
  task automatic pulses(input int n);
    repeat (n) begin ext_pin = 1; repeat (3) cyc(); ext_pin = 0; repeat (3) cyc(); end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    // R1 reset values
    peek(2, 8'hFF, "R1 control reset");
    peek(0, 8'h00, "R1 low reset");
    peek(1, 8'h00, "R1 holding reset");
    peek(3, 8'h00, "R1 status reset");
    check("R1 irq reset", irq, 0);

    // R8 atomic load, R6 hold, R2 internal counting
    wr(2, 8'h88);
    wr(1, 8'h12);
    wr(0, 8'h34);
    ticks(5);
    peek(0, 8'h37, "R6 two ticks swallowed then R2 count");
    rd(0);
    peek(1, 8'h12, "R8 upper byte loaded from holding");

    // R7 read coinciding with carry
    wr(1, 8'h02);
    wr(0, 8'hFF);
    ticks(2);
    tick = 1; rd(0); tick = 0;
    peek(1, 8'h02, "R7 holding keeps pre-carry upper byte");
    peek(0, 8'h00, "R7 low byte after carry");
    rd(0);
    peek(1, 8'h03, "R7 upper byte after carry");

    // R9 16-bit wrap, R10 sticky, R11 irq
    wr(1, 8'hFF);
    wr(0, 8'hFE);
    ticks(4);
    peek(0, 8'h00, "R9 16-bit wrap low");
    peek(3, 8'h01, "R9 16-bit wrap sets flag");
    check("R11 irq masked", irq, 0);
    repeat (3) cyc();
    peek(3, 8'h01, "R10 flag sticky");
    wr(3, 8'h03);
    check("R11 irq with enable", irq, 1);
    wr(3, 8'h02);
    check("R11 irq after clear", irq, 0);

    // R9 8-bit mode
    wr(2, 8'hC8);
    wr(1, 8'h55);
    wr(0, 8'hFE);
    ticks(4);
    peek(0, 8'h00, "R9 8-bit wrap low");
    peek(3, 8'h03, "R9 8-bit wrap sets flag");
    check("R11 irq raised", irq, 1);
    wr(1, 8'h00);
    rd(0);
    peek(1, 8'h55, "R9 upper byte held in 8-bit mode");
    wr(3, 8'h00);

    // R10 clear coinciding with overflow
    wr(0, 8'hFF);
    ticks(2);
    tick = 1; wr(3, 8'h00); tick = 0;
    peek(3, 8'h01, "R10 overflow beats clear");
    peek(0, 8'h00, "R10 wrap happened");
    wr(3, 8'h00);

    // R4 prescaler 1:4, R5 clear on write
    wr(2, 8'h81);
    wr(1, 8'h00);
    wr(0, 8'h00);
    ticks(10);
    peek(0, 8'h02, "R4 1:4 prescale");
    ticks(3);
    wr(0, 8'h10);
    ticks(5);
    peek(0, 8'h10, "R5 prescaler cleared by write");
    peek(2, 8'h81, "R5 control unchanged by write");

    // R3 external edges
    wr(2, 8'hA8);
    wr(0, 8'h00);
    ticks(2);
    pulses(3);
    repeat (4) cyc();
    peek(0, 8'h03, "R3 rising edges");
    wr(2, 8'hB8);
    pulses(2);
    repeat (4) cyc();
    peek(0, 8'h05, "R3 falling edges");

    // R12 timer off
    wr(2, 8'h08);
    ticks(5);
    peek(0, 8'h05, "R12 no count when off");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule